// File: doc/BRIEF.md
# DDR SDRAM Power-Up Init Sequencer

This block brings DDR SDRAM ranks out of power-up. A start pulse arrives after the memory clock frequency has been set. The block then waits a fixed settling time, measured in microsecond ticks. After that it runs the initialisation command program on each populated rank in turn. It drives a single-cycle command strobe, a command code, a full byte address and a DRAM row/column word address toward a PHY model.

Each rank is programmed in the same order:
1. A quiet NOP.
2. An all-bank precharge.
3. Two low mode-register accesses, each followed by a short wait.
4. A second precharge.
5. A train of auto-refresh cycles, each followed by a long wait.
6. The final mode-register load, whose address encodes CAS latency and burst length.

The byte address of each command is the rank's base address plus a fixed offset. The DRAM word address is that offset with the three byte-select bits of the 64-bit bus dropped. The base of every rank after the first comes from the end value of the preceding rank, counted in 32 MiB units. The block raises done once the last rank has received its final mode-register load.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset the block issues no command (cmd_vld_o low, cmd_o, addr_o and mr_o all zero) and done_o is low until start_i is seen.
- R2: A start accepted in the idle or done state is followed by INIT_US (200) microsecond ticks, counted from the cycle after start. The first command of the run appears in the cycle after the last of those ticks.
- R3: Command codes are NOP=0, PRE=1, MRS=2, REF=3. Each rank receives exactly 14 commands with these byte offsets: NOP 0x1F000, PRE 0x1F000, MRS 0x2000, MRS 0x800, PRE 0x1F200, REF_CNT (8) times REF 0x1F300, then MRS with the mode offset.
- R4: Every command strobe lasts one cycle and is followed by at least one idle cycle.
- R5: After each of the two low mode-register accesses (offsets 0x2000 and 0x800), the next command waits exactly MRS_US (1) ticks, counted from the cycle after the strobe.
- R6: After each refresh, the next command waits exactly REF_US (100) ticks, counted the same way.
- R7: The mode offset is 0x150 for cas_code_i=01 (CL2), 0x350 for 10 (CL2.5) and 0x1D0 for 11 or 00 (CL3). Setting bl8_i adds 0x008. In offset bits, [9:7] hold the CL field, bit 6 is set, and [5:3] hold the burst length (010=4, 011=8).
- R8: While a command is valid, mr_o equals the command's byte offset shifted right by 3.
- R9: addr_o = rank base + offset. Rank 0 has base 0. Rank n+1 has base rank_end_i[n] × 2^25. Ranks 0 to num_ranks_i-1 are run in increasing order.
- R10: done_o rises two cycles after the strobe of the last rank's final MRS. It then stays high with no further commands until a new start, which clears it in the next cycle.
- R11: num_ranks_i, cas_code_i, bl8_i and rank_end_i are captured at an accepted start. Later changes, and start pulses during a run, have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the sequence (accepted when idle or done) |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| num_ranks_i | input | RANK_W (2) | Number of populated ranks, 1..MAX_RANKS |
| cas_code_i | input | 2 | CAS latency choice: 01=CL2, 10=CL2.5, else CL3 |
| bl8_i | input | 1 | Burst length 8 when set, 4 otherwise |
| rank_end_i | input | (MAX_RANKS-1)*SIZE_W (8) | End value of each rank but the last, in 32 MiB units |
| cmd_vld_o | output | 1 | Command strobe |
| cmd_o | output | 2 | Command code |
| addr_o | output | ADDR_W (33) | Byte address of the command |
| mr_o | output | WORD_W (14) | DRAM word address (offset >> 3) |
| done_o | output | 1 | Initialisation complete |

## Verification
The sequence is run with four configurations:
- one rank with CL2 and burst 4;
- two ranks with CL2.5 and burst 8, with the second rank at a small base;
- two ranks using code 11 with the largest base;
- a single rank using code 00 with burst 8.

Together these separate each CL encoding and the burst-length offset from one another, and separate rank-0 offsets from the rank-base addition. The top end value exposes any truncation of the base.

Tick counts between commands tell the 1 µs, 100 µs and 200 µs waits apart, including off-by-one counts. One run changes every configuration input and pulses start mid-sequence, to show the captured configuration governs the whole run.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_MRS = 2'd2,
    CMD_REF = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    S_NOP, S_PRE_A, S_MRL_A, S_MRL_B, S_PRE_B, S_REF, S_MRS
  } step_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PWR, ST_CMD, ST_WAIT, ST_DONE
  } state_e;

  localparam int OFS_W   = 17;
  localparam int BYTE_SH = 3;   // byte lanes of a 64-bit bus
  localparam int RANK_SH = 25;  // 32 MiB granule

  localparam logic [OFS_W-1:0] OFS_QUIET = 17'h1F000;
  localparam logic [OFS_W-1:0] OFS_PRE_B = 17'h1F200;
  localparam logic [OFS_W-1:0] OFS_REF   = 17'h1F300;
  localparam logic [OFS_W-1:0] OFS_MRL_A = 17'h02000;
  localparam logic [OFS_W-1:0] OFS_MRL_B = 17'h00800;

  function automatic logic [2:0] cl_field(input logic [1:0] code);
    case (code)
      2'b01:   return 3'b010;  // CL2
      2'b10:   return 3'b110;  // CL2.5
      default: return 3'b011;  // CL3
    endcase
  endfunction

  function automatic step_e next_step(input step_e s);
    case (s)
      S_NOP:   return S_PRE_A;
      S_PRE_A: return S_MRL_A;
      S_MRL_A: return S_MRL_B;
      S_MRL_B: return S_PRE_B;
      S_PRE_B: return S_REF;
      default: return S_MRS;
    endcase
  endfunction

endpackage

// File: rtl/ddr_us_timer.sv
module ddr_us_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  // zero-length wait expires at once; otherwise on the last tick
  assign expire_o = !load_i && ((cnt_q == '0) || (tick_i && cnt_q == CNT_W'(1)));

endmodule

// File: rtl/ddr_mode_addr.sv
module ddr_mode_addr
  import ddr_init_pkg::*;
(
  input  logic [1:0]       cas_code_i,
  input  logic             bl8_i,
  output logic [OFS_W-1:0] ofs_o
);

  logic [2:0] bl_f;

  assign bl_f  = bl8_i ? 3'b011 : 3'b010;
  // [9:7] CL, [6] burst type, [5:3] BL, [2:0] byte lane
  assign ofs_o = {{(OFS_W-10){1'b0}}, cl_field(cas_code_i), 1'b1, bl_f, 3'b000};

endmodule

// File: rtl/ddr_rank_base.sv
module ddr_rank_base
  import ddr_init_pkg::*;
#(
  parameter int MAX_RANKS = 2,
  parameter int SIZE_W    = 8,
  parameter int IDX_W     = 1,
  parameter int ADDR_W    = SIZE_W + RANK_SH
) (
  input  logic [IDX_W-1:0]                rank_i,
  input  logic [(MAX_RANKS-1)*SIZE_W-1:0] rank_end_i,
  output logic [ADDR_W-1:0]               base_o
);

  logic [ADDR_W-1:0] base_tbl [MAX_RANKS];

  assign base_tbl[0] = '0;

  for (genvar r = 1; r < MAX_RANKS; r++) begin : g_base
    assign base_tbl[r] = ADDR_W'(rank_end_i[(r-1)*SIZE_W +: SIZE_W]) << RANK_SH;
  end

  always_comb begin
    base_o = '0;
    for (int r = 0; r < MAX_RANKS; r++) begin
      if (int'(rank_i) == r) base_o = base_tbl[r];
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int MAX_RANKS = 2,
  parameter int SIZE_W    = 8,
  parameter int INIT_US   = 200,
  parameter int MRS_US    = 1,
  parameter int REF_US    = 100,
  parameter int REF_CNT   = 8,
  localparam int RANK_W   = $clog2(MAX_RANKS + 1),
  localparam int ADDR_W   = SIZE_W + RANK_SH,
  localparam int WORD_W   = OFS_W - BYTE_SH
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic                            us_tick_i,
  input  logic [RANK_W-1:0]               num_ranks_i,
  input  logic [1:0]                      cas_code_i,
  input  logic                            bl8_i,
  input  logic [(MAX_RANKS-1)*SIZE_W-1:0] rank_end_i,
  output logic                            cmd_vld_o,
  output logic [1:0]                      cmd_o,
  output logic [ADDR_W-1:0]               addr_o,
  output logic [WORD_W-1:0]               mr_o,
  output logic                            done_o
);

  localparam int IDX_W  = (MAX_RANKS > 1) ? $clog2(MAX_RANKS) : 1;
  localparam int MAX_US = (INIT_US > REF_US) ? ((INIT_US > MRS_US) ? INIT_US : MRS_US)
                                             : ((REF_US > MRS_US) ? REF_US : MRS_US);
  localparam int CNT_W  = $clog2(MAX_US + 1);
  localparam int REFI_W = (REF_CNT > 1) ? $clog2(REF_CNT) : 1;

  state_e                          state_q;
  step_e                           step_q;
  logic [IDX_W-1:0]                rank_q, last_q;
  logic [REFI_W-1:0]               ref_q;
  logic [1:0]                      cas_q;
  logic                            bl8_q;
  logic [(MAX_RANKS-1)*SIZE_W-1:0] end_q;

  logic              start_ok, t_load, t_expire;
  logic [CNT_W-1:0]  t_val;
  logic [OFS_W-1:0]  mode_ofs, step_ofs;
  logic [ADDR_W-1:0] rank_base;
  logic [IDX_W-1:0]  last_d;

  assign start_ok = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    if (num_ranks_i == '0)                  last_d = '0;
    else if (int'(num_ranks_i) > MAX_RANKS) last_d = IDX_W'(MAX_RANKS - 1);
    else                                    last_d = IDX_W'(num_ranks_i - RANK_W'(1));
  end

  function automatic logic [CNT_W-1:0] wait_of(input step_e s);
    case (s)
      S_MRL_A, S_MRL_B: return CNT_W'(MRS_US);
      S_REF:            return CNT_W'(REF_US);
      default:          return '0;
    endcase
  endfunction

  assign t_load = start_ok || (state_q == ST_CMD);
  assign t_val  = start_ok ? CNT_W'(INIT_US) : wait_of(step_q);

  ddr_us_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .tick_i     (us_tick_i),
    .expire_o   (t_expire)
  );

  ddr_mode_addr i_mode (
    .cas_code_i (cas_q),
    .bl8_i      (bl8_q),
    .ofs_o      (mode_ofs)
  );

  ddr_rank_base #(
    .MAX_RANKS (MAX_RANKS),
    .SIZE_W    (SIZE_W),
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W)
  ) i_base (
    .rank_i     (rank_q),
    .rank_end_i (end_q),
    .base_o     (rank_base)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= S_NOP;
      rank_q  <= '0;
      last_q  <= '0;
      ref_q   <= '0;
      cas_q   <= '0;
      bl8_q   <= 1'b0;
      end_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            state_q <= ST_PWR;
            step_q  <= S_NOP;
            rank_q  <= '0;
            ref_q   <= '0;
            last_q  <= last_d;
            cas_q   <= cas_code_i;
            bl8_q   <= bl8_i;
            end_q   <= rank_end_i;
          end
        end
        ST_PWR:  if (t_expire) state_q <= ST_CMD;
        ST_CMD:  state_q <= ST_WAIT;
        ST_WAIT: begin
          if (t_expire) begin
            if (step_q == S_MRS) begin
              if (rank_q == last_q) begin
                state_q <= ST_DONE;
              end else begin
                rank_q  <= rank_q + IDX_W'(1);
                step_q  <= S_NOP;
                state_q <= ST_CMD;
              end
            end else if (step_q == S_REF && ref_q != REFI_W'(REF_CNT - 1)) begin
              ref_q   <= ref_q + REFI_W'(1);
              state_q <= ST_CMD;
            end else begin
              step_q  <= next_step(step_q);
              ref_q   <= '0;
              state_q <= ST_CMD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (step_q)
      S_NOP, S_PRE_A: step_ofs = OFS_QUIET;
      S_MRL_A:        step_ofs = OFS_MRL_A;
      S_MRL_B:        step_ofs = OFS_MRL_B;
      S_PRE_B:        step_ofs = OFS_PRE_B;
      S_REF:          step_ofs = OFS_REF;
      default:        step_ofs = mode_ofs;
    endcase
  end

  cmd_e step_cmd;
  always_comb begin
    case (step_q)
      S_NOP:            step_cmd = CMD_NOP;
      S_PRE_A, S_PRE_B: step_cmd = CMD_PRE;
      S_REF:            step_cmd = CMD_REF;
      default:          step_cmd = CMD_MRS;
    endcase
  end

  assign cmd_vld_o = (state_q == ST_CMD);
  assign cmd_o     = cmd_vld_o ? step_cmd : CMD_NOP;
  assign addr_o    = cmd_vld_o ? rank_base + ADDR_W'(step_ofs) : '0;
  assign mr_o      = cmd_vld_o ? step_ofs[OFS_W-1:BYTE_SH] : '0;
  assign done_o    = (state_q == ST_DONE);

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
  import ddr_init_pkg::*;
#(
  parameter int REF_US  = 100,
  parameter int REF_CNT = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       us_tick_i,
  input logic       cmd_vld_o,
  input logic [1:0] cmd_o,
  input logic       done_o
);

  int   tcnt_q;
  int   refs_q;
  logic ref_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q     <= 0;
      refs_q     <= 0;
      ref_pend_q <= 1'b0;
    end else if (cmd_vld_o) begin
      tcnt_q     <= 0;
      ref_pend_q <= (cmd_o == CMD_REF);
      if (cmd_o == CMD_NOP)      refs_q <= 0;
      else if (cmd_o == CMD_REF) refs_q <= refs_q + 1;
    end else if (us_tick_i) begin
      tcnt_q <= tcnt_q + 1;
    end
  end

  // R4
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |=> !cmd_vld_o);

  // R6
  ref_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && ref_pend_q) |-> (tcnt_q == REF_US));

  // R3
  ref_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && cmd_o == CMD_MRS && refs_q != 0) |-> (refs_q == REF_CNT));

  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_vld_o);

  // R10
  done_after_mrs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(cmd_vld_o, 2) && $past(cmd_o, 2) == CMD_MRS));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .REF_US  (REF_US),
  .REF_CNT (REF_CNT)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .us_tick_i (us_tick_i),
  .cmd_vld_o (cmd_vld_o),
  .cmd_o     (cmd_o),
  .done_o    (done_o)
);

// File: tb/test_ddr_init_seq.sv
`timescale 1ns/1ps
module test_ddr_init_seq;

  localparam int TICK_DIV = 10;
  localparam int PER_RANK = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        us_tick = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  num_ranks = 2'd1;
  logic [1:0]  cas_code = 2'b01;
  logic        bl8 = 1'b0;
  logic [7:0]  rank_end = 8'h0;
  logic        cmd_vld;
  logic [1:0]  cmd;
  logic [32:0] addr;
  logic [13:0] mr;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ddr_init_seq i_ddr_init_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .us_tick_i   (us_tick),
    .num_ranks_i (num_ranks),
    .cas_code_i  (cas_code),
    .bl8_i       (bl8),
    .rank_end_i  (rank_end),
    .cmd_vld_o   (cmd_vld),
    .cmd_o       (cmd),
    .addr_o      (addr),
    .mr_o        (mr),
    .done_o      (done)
  );

  // log of observed commands
  logic [1:0]  lg_cmd  [64];
  logic [32:0] lg_addr [64];
  logic [13:0] lg_mr   [64];
  int          lg_gap  [64];
  int n_log = 0, acc = 0, cyc = 0, b2b = 0, last_cmd_t = 0, done_t = 0;
  bit skip = 0, prev_vld = 0, prev_done = 0, arm_start = 0;

  initial begin
    int tdiv = 0;
    forever begin
      @(negedge clk);
      tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      us_tick = tick_en && (tdiv == 0);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (skip) skip = 0;
      else if (us_tick) acc++;
      if (start && arm_start) acc = 0;
      if (cmd_vld) begin
        if (prev_vld) b2b++;
        if (n_log < 64) begin
          lg_cmd[n_log]  = cmd;
          lg_addr[n_log] = addr;
          lg_mr[n_log]   = mr;
          lg_gap[n_log]  = acc;
        end
        n_log++;
        acc = 0;
        skip = 1;
        last_cmd_t = cyc;
      end
      prev_vld = cmd_vld;
      if (done && !prev_done) done_t = cyc;
      prev_done = done;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cmd(input int k);
    if (k == 0) return 0;
    if (k == 1 || k == 4) return 1;
    if (k >= 5 && k <= 12) return 3;
    return 2;
  endfunction

  function automatic longint exp_ofs(input int k, input logic [1:0] c, input logic b8);
    longint m;
    case (k)
      0, 1: return 'h1F000;
      2:    return 'h2000;
      3:    return 'h800;
      4:    return 'h1F200;
      13: begin
        m = (c == 2'b01) ? 'h150 : (c == 2'b10) ? 'h350 : 'h1D0;
        return m + (b8 ? 'h8 : 0);
      end
      default: return 'h1F300;
    endcase
  endfunction

  task automatic pulse_start(input bit arm);
    @(negedge clk);
    arm_start = arm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    arm_start = 0;
  endtask

  task automatic clear_log();
    n_log = 0; b2b = 0; done_t = 0; last_cmd_t = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 40000) begin
      @(posedge clk); #1; t++;
    end
    chk("R10 done reached", done, 1);
  endtask

  task automatic verify(input int nr, input logic [1:0] c, input logic b8, input logic [7:0] e0);
    chk("R3 command count", n_log, nr * PER_RANK);
    if (n_log != nr * PER_RANK) return;
    for (int r = 0; r < nr; r++) begin
      longint base = (r == 0) ? 0 : (longint'(e0) << 25);
      for (int k = 0; k < PER_RANK; k++) begin
        int i = r * PER_RANK + k;
        longint ofs = exp_ofs(k, c, b8);
        chk("R3 cmd code", lg_cmd[i], exp_cmd(k));
        if (k == 13) chk("R7 mode address", lg_addr[i], base + ofs);
        else         chk("R9 rank address", lg_addr[i], base + ofs);
        chk("R8 word address", lg_mr[i], ofs >> 3);
        if (r == 0 && k == 0)      chk("R2 power-up wait", lg_gap[i], 200);
        if (k == 3 || k == 4)      chk("R5 mode-low wait", lg_gap[i], 1);
        if (k >= 6)                chk("R6 refresh wait", lg_gap[i], 100);
      end
    end
    chk("R4 back-to-back strobes", b2b, 0);
    chk("R10 done latency", done_t - last_cmd_t, 2);
  endtask

  task automatic run_seq(input int nr, input logic [1:0] c, input logic b8, input logic [7:0] e0);
    @(negedge clk);
    num_ranks = 2'(nr); cas_code = c; bl8 = b8; rank_end = e0;
    clear_log();
    pulse_start(1);
    #1;
    chk("R10 done cleared by start", done, 0);
    wait_done();
    verify(nr, c, b8, e0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset strobe", cmd_vld, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset addr", addr, 0);
    chk("R1 reset mr", mr, 0);
    chk("R1 reset cmd", cmd, 0);
    @(negedge clk); rst_n = 1'b1; tick_en = 1'b1;
    repeat (300) @(negedge clk);
    chk("R1 idle without start", n_log, 0);
    chk("R1 idle done", done, 0);
  endtask

  task automatic t_cl2_one();       run_seq(1, 2'b01, 1'b0, 8'h00); endtask
  task automatic t_cl25_two_bl8();  run_seq(2, 2'b10, 1'b1, 8'h04); endtask
  task automatic t_cl3_two_top();   run_seq(2, 2'b11, 1'b0, 8'hFF); endtask
  task automatic t_code0_bl8();     run_seq(1, 2'b00, 1'b1, 8'h00); endtask

  task automatic t_latch_ignore();
    @(negedge clk);
    num_ranks = 2'd1; cas_code = 2'b01; bl8 = 1'b0; rank_end = 8'h10;
    clear_log();
    pulse_start(1);
    repeat (50) @(negedge clk);
    num_ranks = 2'd2; cas_code = 2'b11; bl8 = 1'b1; rank_end = 8'h33;
    pulse_start(0);           // R11: start while running is ignored
    repeat (3000) @(negedge clk);
    pulse_start(0);
    wait_done();
    verify(1, 2'b01, 1'b0, 8'h10);   // R11 captured config governs
    repeat (200) @(negedge clk);
    chk("R10 done held", done, 1);
    chk("R11 no extra commands", n_log, PER_RANK);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_cl2_one();
    t_cl25_two_bl8();
    t_cl3_two_top();
    t_code0_bl8();
    t_latch_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule